// File: doc/BRIEF.md
# PWM Stuck-Input Activity Detector

This block watches a group of PWM input lines on the system clock and decides whether they are still switching. Each line is brought into the clock domain through a two-flop synchronizer. A transition on a line restarts a per-line idle counter. If any one line stays high or stays low for longer than a programmable number of clocks, the whole block reports a fault on one active-low shutdown output. A per-line status vector shows which lines are stuck.

A separate qualifier input comes from upstream logic that has judged the current PWM frame to be malformed. While the qualifier is high, the shutdown output goes low in the same cycle, with no timeout. The fault is not latched and clears without help. Three conditions must all hold for it to clear: the qualifier is low, no line is stuck, and every line has shown at least one transition since the fault was raised.

Top module: `pwm_act_det`

## Requirements
- R1: A line whose level changes at intervals shorter than `tmo_cycles` clocks never sets its `ch_stuck` bit, and it never drives `sd_n` low.
- R2: After the last change on line i, `ch_stuck[i]` reads 0 through the first `tmo_cycles`+2 rising clock edges and reads 1 after edge `tmo_cycles`+3. This holds when the line is held high and when it is held low. Bit i of `ch_stuck` belongs to bit i of `pwm_in`.
- R3: One clock after any `ch_stuck` bit becomes 1, `sd_n` goes low, which is edge `tmo_cycles`+4 after the last change. Before that edge `sd_n` stays high.
- R4: While `frame_bad` is 1, `sd_n` is 0 in the same cycle, combinationally. A `frame_bad` value held across a clock edge raises the fault state.
- R5: The fault clears by itself once `frame_bad` is 0, no line is stuck, and every line has had a synchronized transition since the fault was raised. `sd_n` then returns to 1. A transition seen by the detector on edge k clears the fault at edge k+1.
- R6: While any line has not yet shown a transition since the fault was raised, `sd_n` stays 0, even when the other lines are switching.
- R7: A synchronous active-high `rst` clears all counters, the fault state and the transition flags. With `frame_bad` at 0, `sd_n` reads 1 and `ch_stuck` reads all zeros after a clock edge with `rst` high.
- R8: `sd_n` is active low: 1 means normal operation and 0 means shut down. `tmo_cycles` must be at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | N_CH | Asynchronous PWM lines to watch |
| frame_bad | input | 1 | Upstream invalid-frame qualifier, active high |
| tmo_cycles | input | TMO_W | Idle limit in clocks, at least 1 |
| sd_n | output | 1 | Shutdown, active low |
| ch_stuck | output | N_CH | Per-line stuck status |

## Verification
The bench samples exactly at the stuck boundary: one clock before `ch_stuck` rises, the clock it rises, and the first clock `sd_n` falls. A design that is off by one in the synchronizer or the counter compare fails one of these three samples. The bench holds lines both high and low, so a detector that only sees one polarity shows no fault on the other. After an invalid-frame fault, it toggles all lines but one and expects `sd_n` to stay low. A design that clears on the first transition, or that latches forever, is caught here. Random switching intervals below the limit, with random qualifier pulses, check that a healthy stream never trips the block and that it recovers after each pulse.

// File: rtl/pad_pkg.sv
package pad_pkg;

    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } fault_st_e;

    typedef struct packed {
        logic edge_seen;
        logic stuck;
    } chan_stat_t;

    function automatic logic cnt_expired(input logic [31:0] cnt, input logic [31:0] limit);
        return cnt >= limit;
    endfunction

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int unsigned STAGES = pad_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic edge_o
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], async_i};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign edge_o = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pad_chan_timer.sv
module pad_chan_timer #(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             stuck_o
);
    import pad_pkg::*;

    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || edge_i) begin
            cnt_q <= '0;
        end else if (cnt_q < limit_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stuck_o = cnt_expired(32'(cnt_q), 32'(limit_i));
endmodule

// File: rtl/pad_fault_ctl.sv
module pad_fault_ctl #(
    parameter int unsigned N_CH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  pad_pkg::chan_stat_t [N_CH-1:0] stat_i,
    input  logic                       frame_bad,
    output logic                       sd_n
);
    import pad_pkg::*;

    fault_st_e        st_q;
    logic [N_CH-1:0]  seen_q;
    logic [N_CH-1:0]  edges;
    logic [N_CH-1:0]  stucks;
    logic             any_stuck;
    logic             all_seen;

    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            edges[i]  = stat_i[i].edge_seen;
            stucks[i] = stat_i[i].stuck;
        end
        any_stuck = |stucks;
        all_seen  = &(seen_q | edges);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_RUN;
            seen_q <= '0;
        end else begin
            case (st_q)
                ST_RUN: begin
                    seen_q <= '0;
                    if (frame_bad || any_stuck) st_q <= ST_FAULT;
                end
                default: begin
                    seen_q <= seen_q | edges;
                    if (!frame_bad && !any_stuck && all_seen) begin
                        st_q   <= ST_RUN;
                        seen_q <= '0;
                    end
                end
            endcase
        end
    end

    assign sd_n = !(st_q == ST_FAULT || frame_bad);
endmodule

// File: rtl/pwm_act_det.sv
module pwm_act_det #(
    parameter int unsigned N_CH  = 4,
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CH-1:0]  pwm_in,
    input  logic             frame_bad,
    input  logic [TMO_W-1:0] tmo_cycles,
    output logic             sd_n,
    output logic [N_CH-1:0]  ch_stuck
);
    import pad_pkg::*;

    chan_stat_t [N_CH-1:0] stat;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic edge_w;
        logic stuck_w;

        pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (pwm_in[g]),
            .edge_o  (edge_w)
        );

        pad_chan_timer #(.TMO_W(TMO_W)) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .edge_i  (edge_w),
            .limit_i (tmo_cycles),
            .stuck_o (stuck_w)
        );

        assign stat[g].edge_seen = edge_w;
        assign stat[g].stuck     = stuck_w;
        assign ch_stuck[g]       = stuck_w;
    end

    pad_fault_ctl #(.N_CH(N_CH)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .stat_i    (stat),
        .frame_bad (frame_bad),
        .sd_n      (sd_n)
    );
endmodule

// File: rtl/pwm_act_det_chk.sv
module pwm_act_det_chk #(
    parameter int unsigned N_CH = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            frame_bad,
    input logic            sd_n,
    input logic [N_CH-1:0] ch_stuck
);
    AST_STUCK_TRIPS: assert property (@(posedge clk) disable iff (rst)
        (|ch_stuck) |=> !sd_n); // R3

    AST_FRAME_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
        frame_bad |-> !sd_n); // R4

    AST_CLEAR_NO_STUCK: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_n) |-> ($past(ch_stuck) == '0)); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (sd_n || frame_bad)); // R7
endmodule

bind pwm_act_det pwm_act_det_chk #(.N_CH(N_CH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .frame_bad (frame_bad),
    .sd_n      (sd_n),
    .ch_stuck  (ch_stuck)
);

// File: tb/pwm_act_det_tb_top.sv
module pwm_act_det_tb_top;
    localparam int N  = 4;
    localparam int TW = 16;
    localparam int T  = 24;
    localparam int MAXG = T / 2 - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pwm = '0;
    logic          fb  = 1'b0;
    logic [TW-1:0] tmo = TW'(T);
    logic          sd_n;
    logic [N-1:0]  ch_stuck;

    logic [N-1:0]  en    = '0;
    logic [N-1:0]  fmask = '0;
    int            gap [N];
    int            checks = 0;
    int            errors = 0;

    always #4 clk = ~clk;

    pwm_act_det #(.N_CH(N), .TMO_W(TW)) dut_i (
        .clk(clk), .rst(rst), .pwm_in(pwm), .frame_bad(fb),
        .tmo_cycles(tmo), .sd_n(sd_n), .ch_stuck(ch_stuck)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int onehot(input int c);
        return 1 << c;
    endfunction

    // drive at a negedge, then advance to the next negedge
    task automatic step();
        for (int c = 0; c < N; c++) begin
            if (fmask[c]) begin
                pwm[c] = ~pwm[c];
            end else if (en[c]) begin
                if (gap[c] == 0) begin
                    pwm[c] = ~pwm[c];
                    gap[c] = $urandom_range(MAXG, 1);
                end else begin
                    gap[c]--;
                end
            end
        end
        fmask = '0;
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic stuck_case(input int c, input logic lvl);
        en[c] = 1'b0;
        if (pwm[c] == lvl) begin
            fmask[c] = 1'b1;
            step();
        end
        fmask[c] = 1'b1;
        step();                        // one edge since the final change
        steps(T + 1);                  // edge T+2
        chk("R2 not yet stuck", int'(ch_stuck[c]), 0);
        chk("R3 sd_n still high", int'(sd_n), 1);
        step();                        // edge T+3
        chk("R2 stuck bit", int'(ch_stuck), onehot(c));
        chk("R2 stuck level held", int'(pwm[c]), int'(lvl));
        chk("R3 sd_n before trip", int'(sd_n), 1);
        step();                        // edge T+4
        chk("R3 sd_n low", int'(sd_n), 0);
        en[c] = 1'b1;
        gap[c] = 0;
        steps(3 * T);
        chk("R5 recovered sd_n", int'(sd_n), 1);
        chk("R5 recovered stuck", int'(ch_stuck), 0);
    endtask

    initial begin
        for (int c = 0; c < N; c++) gap[c] = 0;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        steps(3);
        chk("R7 reset sd_n", int'(sd_n), 1);
        chk("R7 reset stuck", int'(ch_stuck), 0);
        chk("R8 idle level", int'(sd_n), 1);
        rst = 1'b0;
        en = '1;

        // R1: random healthy switching
        for (int i = 0; i < 400; i++) begin
            step();
            chk("R1 healthy sd_n", int'(sd_n), 1);
            chk("R1 healthy stuck", int'(ch_stuck), 0);
        end

        // R2/R3: each line held low and held high
        for (int c = 0; c < N; c++) begin
            stuck_case(c, 1'b0);
            stuck_case(c, 1'b1);
        end

        // R4/R5: random invalid-frame pulses over a healthy stream
        for (int k = 0; k < 6; k++) begin
            steps($urandom_range(30, 10));
            fb = 1'b1;
            #1;
            chk("R4 immediate", int'(sd_n), 0);
            step();
            fb = 1'b0;
            #1;
            chk("R4 fault held", int'(sd_n), 0);
            steps(3 * T);
            chk("R5 pulse recovery", int'(sd_n), 1);
        end

        // R6: all lines quiet, recovery needs every line
        tmo = TW'(200);
        en = '0;
        steps(3);
        fb = 1'b1;
        #1;
        chk("R4 quiet immediate", int'(sd_n), 0);
        step();
        fb = 1'b0;
        steps(3);
        chk("R6 no edges", int'(sd_n), 0);
        fmask = '1;
        fmask[N-1] = 1'b0;
        step();
        steps(5);
        chk("R6 one line missing", int'(sd_n), 0);
        fmask[N-1] = 1'b1;
        step();
        chk("R5 pipeline edge 1", int'(sd_n), 0);
        steps(5);
        chk("R5 last line seen", int'(sd_n), 1);

        // R7: reset during a fault
        fb = 1'b1;
        step();
        fb = 1'b0;
        #1;
        chk("R7 fault before reset", int'(sd_n), 0);
        rst = 1'b1;
        step();
        chk("R7 reset clears sd_n", int'(sd_n), 1);
        chk("R7 reset clears stuck", int'(ch_stuck), 0);
        rst = 1'b0;
        step();
        chk("R7 after reset", int'(sd_n), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule